// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block is a small, fully associative cache of page translations that sits inside a memory management unit. A lookup presents a virtual address, the current context tag, and the kind of access (read or write, user or supervisor). In the same cycle the block returns one of three outcomes. On a hit it gives the physical address. On a permission fault the entry matched but the access is not allowed. On a miss no valid entry matches the page number and context.

On a miss the block raises a refill request toward an external page walker and holds it until the walker answers. A mapped answer is installed in a free slot. If no slot is free, a victim is picked in rotation and its metadata is shown on a write-back port in the same cycle. An unmapped answer raises a page fault and installs nothing. Each entry carries a context tag, so entries of different processes can live side by side and a context switch needs no flush. Software can clear the whole cache or drop every entry for one page number.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, `rf_req` is 0, and any lookup reports a miss.
- R2: A lookup whose page number and context match a valid entry, and whose access is permitted, raises `lk_hit` in the same cycle. `lk_paddr` is then the entry's frame number concatenated with the 12-bit page offset of `lk_vaddr`.
- R3: An entry hits only when its context tag equals `lk_ctx`. A valid entry holding the same page number under another context produces a miss.
- R4: Permission bits are bit 0 = writable and bit 1 = user-accessible. A matching lookup that writes to a non-writable page, or makes a user access to a non-user page, raises `lk_perm_fault` with `lk_hit` and `lk_miss` low, and starts no refill.
- R5: A miss raises `lk_miss` in the same cycle. From the next cycle `rf_req` is high with `rf_vpn`/`rf_ctx` set to the missed page and context. These stay unchanged until a walker response arrives, even if more misses occur in between.
- R6: A response with `rf_rsp_mapped`=1 installs the entry with the returned frame number and permissions. A lookup in the next cycle hits.
- R7: A response with `rf_rsp_mapped`=0 raises `page_fault` in the same cycle and installs nothing. The page still misses afterwards.
- R8: While an invalid slot exists, an install takes the lowest-numbered invalid slot and `wb_valid` stays 0.
- R9: When all slots are valid, an install evicts a slot chosen in rotation, starting at slot 0 after reset. In the response cycle `wb_valid` pulses with the victim's page number, context and modified bit.
- R10: An install clears the modified bit. A permitted write hit sets it, and read hits leave it unchanged. The write-back port reports it.
- R11: `flush_all` invalidates every entry from the next cycle on.
- R12: `inv_valid` with `inv_vpn` invalidates every entry holding that page number, in any context, from the next cycle on. Other entries are kept.
- R13: Invalidation does not move the rotation pointer. A slot freed by invalidation is refilled without write-back. Rotation then continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_ctx | input | CTX_W | Current context tag |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made in user mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid matching entry |
| lk_perm_fault | output | 1 | Entry matched but access denied |
| lk_paddr | output | PA_W | Translated physical address (zero unless hit) |
| rf_req | output | 1 | Refill request to page walker |
| rf_vpn | output | VA_W-12 | Page number to walk |
| rf_ctx | output | CTX_W | Context of the walk |
| rf_rsp_valid | input | 1 | Walker response strobe |
| rf_rsp_mapped | input | 1 | Page is mapped in memory |
| rf_rsp_pfn | input | PA_W-12 | Returned frame number |
| rf_rsp_perm | input | 2 | Returned permissions (bit0 write, bit1 user) |
| page_fault | output | 1 | Walk found the page unmapped |
| flush_all | input | 1 | Invalidate every entry |
| inv_valid | input | 1 | Invalidate entries of one page |
| inv_vpn | input | VA_W-12 | Page number to invalidate |
| wb_valid | output | 1 | Evicted entry metadata valid |
| wb_vpn | output | VA_W-12 | Page number of evicted entry |
| wb_ctx | output | CTX_W | Context of evicted entry |
| wb_modified | output | 1 | Modified bit of evicted entry |

## Verification
Lookups are tried with reads, supervisor writes and user writes against entries that carry all four permission combinations. This separates a true hit from a permission fault and from a miss. The same page number is looked up under a foreign context to show that the tag takes part in the match. The cache is filled and then overfilled, so the write-back sequence exposes slot order, the rotation pointer and the modified bit. Per-page invalidation, a full flush and a second miss during an outstanding refill each show that entries and the pending request are kept or dropped as required.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam int OFF_W = 12;

    typedef struct packed {
        logic usr;
        logic wr;
    } perm_t;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_PERM  = 2'd3
    } lk_res_e;

    function automatic logic perm_allows(perm_t p, logic is_wr, logic is_usr);
        return !(is_wr && !p.wr) && !(is_usr && !p.usr);
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int CTX_W   = 4
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    input  logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx,
    input  logic [VPN_W-1:0]              key_vpn,
    input  logic [CTX_W-1:0]              key_ctx,
    input  logic [VPN_W-1:0]              kill_vpn,
    output logic [ENTRIES-1:0]            lk_match,
    output logic [ENTRIES-1:0]            kill_match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]   = valid[g] && (ent_vpn[g] == key_vpn) && (ent_ctx[g] == key_ctx);
        assign kill_match[g] = valid[g] && (ent_vpn[g] == kill_vpn);
    end
endmodule

// File: rtl/tlb_onehot_enc.sv
module tlb_onehot_enc #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               advance,
    output logic [IDX_W-1:0]   slot,
    output logic               full
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign full = &valid;
    assign slot = full ? rr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int CTX_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [CTX_W-1:0]      lk_ctx,
    input  logic                  lk_write,
    input  logic                  lk_user,
    output logic                  lk_hit,
    output logic                  lk_miss,
    output logic                  lk_perm_fault,
    output logic [PA_W-1:0]       lk_paddr,
    output logic                  rf_req,
    output logic [VA_W-OFF_W-1:0] rf_vpn,
    output logic [CTX_W-1:0]      rf_ctx,
    input  logic                  rf_rsp_valid,
    input  logic                  rf_rsp_mapped,
    input  logic [PA_W-OFF_W-1:0] rf_rsp_pfn,
    input  logic [1:0]            rf_rsp_perm,
    output logic                  page_fault,
    input  logic                  flush_all,
    input  logic                  inv_valid,
    input  logic [VA_W-OFF_W-1:0] inv_vpn,
    output logic                  wb_valid,
    output logic [VA_W-OFF_W-1:0] wb_vpn,
    output logic [CTX_W-1:0]      wb_ctx,
    output logic                  wb_modified
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // entry storage
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0]            mod_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][CTX_W-1:0] ctx_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    perm_t [ENTRIES-1:0]           perm_q;

    // pending refill
    logic             pend_q;
    logic [VPN_W-1:0] pend_vpn_q;
    logic [CTX_W-1:0] pend_ctx_q;

    logic [VPN_W-1:0]   key_vpn;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] kill_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   fill_idx;
    logic               full;
    logic               install;
    logic               evict;
    logic               accept_rsp;
    lk_res_e            res;
    perm_t              hit_perm;

    assign key_vpn = lk_vaddr[VA_W-1:OFF_W];

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_cam (
        .valid      (valid_q),
        .ent_vpn    (vpn_q),
        .ent_ctx    (ctx_q),
        .key_vpn    (key_vpn),
        .key_ctx    (lk_ctx),
        .kill_vpn   (inv_vpn),
        .lk_match   (hit_vec),
        .kill_match (kill_vec)
    );

    tlb_onehot_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
        .vec (hit_vec),
        .idx (hit_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vic (
        .clk     (clk),
        .rst     (rst),
        .valid   (valid_q),
        .advance (evict),
        .slot    (fill_idx),
        .full    (full)
    );

    assign hit_perm = perm_q[hit_idx];

    always_comb begin
        res = RES_NONE;
        if (lk_valid) begin
            if (!(|hit_vec))                              res = RES_MISS;
            else if (perm_allows(hit_perm, lk_write, lk_user)) res = RES_HIT;
            else                                          res = RES_PERM;
        end
    end

    assign lk_hit        = (res == RES_HIT);
    assign lk_miss       = (res == RES_MISS);
    assign lk_perm_fault = (res == RES_PERM);
    assign lk_paddr      = lk_hit ? {pfn_q[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;

    assign accept_rsp = rf_rsp_valid && pend_q;
    assign install    = accept_rsp && rf_rsp_mapped;
    assign evict      = install && full;
    assign page_fault = accept_rsp && !rf_rsp_mapped;

    assign rf_req = pend_q;
    assign rf_vpn = pend_vpn_q;
    assign rf_ctx = pend_ctx_q;

    assign wb_valid    = evict;
    assign wb_vpn      = evict ? vpn_q[fill_idx] : '0;
    assign wb_ctx      = evict ? ctx_q[fill_idx] : '0;
    assign wb_modified = evict && mod_q[fill_idx];

    // refill tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_vpn_q <= '0;
            pend_ctx_q <= '0;
        end else if (accept_rsp) begin
            pend_q <= 1'b0;
        end else if (lk_miss && !pend_q) begin
            pend_q     <= 1'b1;
            pend_vpn_q <= key_vpn;
            pend_ctx_q <= lk_ctx;
        end
    end

    // entry update: invalidation first, then write-hit marking, then install
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            mod_q   <= '0;
            vpn_q   <= '0;
            ctx_q   <= '0;
            pfn_q   <= '0;
            perm_q  <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all || (inv_valid && kill_vec[i])) valid_q[i] <= 1'b0;
                if (lk_hit && lk_write && hit_vec[i])        mod_q[i]   <= 1'b1;
                if (install && (fill_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    mod_q[i]   <= 1'b0;
                    vpn_q[i]   <= pend_vpn_q;
                    ctx_q[i]   <= pend_ctx_q;
                    pfn_q[i]   <= rf_rsp_pfn;
                    perm_q[i]  <= perm_t'(rf_rsp_perm);
                end
            end
        end
    end
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_perm_fault,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] valid_q,
    input logic               rf_req,
    input logic [VPN_W-1:0]   rf_vpn,
    input logic               rf_rsp_valid,
    input logic               page_fault,
    input logic               wb_valid,
    input logic               flush_all
);
    // R2: exactly one outcome per lookup
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_perm_fault}) == 1);

    // R3: page number and context select at most one entry
    a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R4: a permission fault never opens a refill
    a_r4_no_walk_on_fault: assert property (@(posedge clk) disable iff (rst)
        lk_perm_fault && !rf_req |=> !rf_req);

    // R5: request held stable until answered
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        rf_req && !rf_rsp_valid |=> rf_req && $stable(rf_vpn));

    // R7: an unmapped answer closes the request
    a_r7_fault_closes: assert property (@(posedge clk) disable iff (rst)
        page_fault |=> !rf_req);

    // R9: write-back only when every slot is occupied
    a_r9_wb_when_full: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (&valid_q));

    // R11: flush empties the array
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_all && !rf_rsp_valid |=> valid_q == '0);
endmodule

bind ctx_tlb ctx_tlb_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_hit        (lk_hit),
    .lk_miss       (lk_miss),
    .lk_perm_fault (lk_perm_fault),
    .hit_vec       (hit_vec),
    .valid_q       (valid_q),
    .rf_req        (rf_req),
    .rf_vpn        (rf_vpn),
    .rf_rsp_valid  (rf_rsp_valid),
    .page_fault    (page_fault),
    .wb_valid      (wb_valid),
    .flush_all     (flush_all)
);

// File: tb/ctx_tlb_tb.sv
module ctx_tlb_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [31:0] lk_vaddr = '0;
    logic [3:0]  lk_ctx = '0;
    logic        lk_hit, lk_miss, lk_perm_fault;
    logic [31:0] lk_paddr;
    logic        rf_req;
    logic [19:0] rf_vpn;
    logic [3:0]  rf_ctx;
    logic        rf_rsp_valid = 0, rf_rsp_mapped = 0;
    logic [19:0] rf_rsp_pfn = '0;
    logic [1:0]  rf_rsp_perm = '0;
    logic        page_fault;
    logic        flush_all = 0, inv_valid = 0;
    logic [19:0] inv_vpn = '0;
    logic        wb_valid, wb_modified;
    logic [19:0] wb_vpn;
    logic [3:0]  wb_ctx;

    int checks = 0;
    int errors = 0;
    logic        s_hit, s_miss, s_pf, s_wb, s_wbm, s_pgf;
    logic [31:0] s_paddr;
    logic [19:0] s_wbv;
    logic [3:0]  s_wbc;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_tlb u_dut (.*);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(logic [19:0] vpn, logic [11:0] off, logic [3:0] ctx, logic wr, logic usr);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_ctx = ctx; lk_write = wr; lk_user = usr;
        #1;
        s_hit = lk_hit; s_miss = lk_miss; s_pf = lk_perm_fault; s_paddr = lk_paddr;
        @(posedge clk); #1;
        lk_valid = 0; lk_write = 0; lk_user = 0;
    endtask

    task automatic respond(string req, logic [19:0] exp_vpn, logic [3:0] exp_ctx,
                           logic mapped, logic [19:0] pfn, logic [1:0] perm);
        @(negedge clk);
        chk(req, "rf_req", rf_req, 1);
        chk(req, "rf_vpn", rf_vpn, exp_vpn);
        chk(req, "rf_ctx", rf_ctx, exp_ctx);
        rf_rsp_valid = 1; rf_rsp_mapped = mapped; rf_rsp_pfn = pfn; rf_rsp_perm = perm;
        #1;
        s_pgf = page_fault; s_wb = wb_valid; s_wbv = wb_vpn; s_wbc = wb_ctx; s_wbm = wb_modified;
        @(posedge clk); #1;
        rf_rsp_valid = 0; rf_rsp_mapped = 0;
    endtask

    task automatic install(string req, logic [19:0] vpn, logic [3:0] ctx, logic [19:0] pfn,
                           logic [1:0] perm, logic exp_wb, logic [19:0] ev_vpn,
                           logic [3:0] ev_ctx, logic ev_mod);
        lookup(vpn, 12'h0, ctx, 0, 0);
        chk("R5", "miss before install", s_miss, 1);
        respond(req, vpn, ctx, 1, pfn, perm);
        chk(req, "page_fault on mapped", s_pgf, 0);
        chk(req, "wb_valid", s_wb, exp_wb);
        if (exp_wb) begin
            chk(req, "wb_vpn", s_wbv, ev_vpn);
            chk(req, "wb_ctx", s_wbc, ev_ctx);
            chk("R10", "wb_modified", s_wbm, ev_mod);
        end
    endtask

    task automatic expect_hit(string req, logic [19:0] vpn, logic [11:0] off, logic [3:0] ctx,
                              logic wr, logic usr, logic [19:0] pfn);
        lookup(vpn, off, ctx, wr, usr);
        chk(req, "hit", s_hit, 1);
        chk(req, "paddr", s_paddr, {pfn, off});
    endtask

    task automatic expect_absent(string req, logic [19:0] vpn, logic [3:0] ctx);
        lookup(vpn, 12'h0, ctx, 0, 0);
        chk(req, "miss", s_miss, 1);
        chk(req, "no hit", s_hit, 0);
        respond(req, vpn, ctx, 0, '0, '0);
        chk("R7", "page_fault", s_pgf, 1);
        chk("R7", "no wb on unmapped", s_wb, 0);
    endtask

    task automatic t_reset();
        chk("R1", "rf_req after reset", rf_req, 0);
        expect_absent("R1", 20'h00100, 4'h1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 8; i++)
            install("R8", 20'h00100 + 20'(i), 4'h1, 20'h00200 + 20'(i), 2'(i), 0, '0, '0, 0);
        for (int i = 0; i < 8; i++)
            expect_hit("R2", 20'h00100 + 20'(i), 12'(12'h0A5 + i * 12'h111), 4'h1, 0, 0, 20'h00200 + 20'(i));
        expect_hit("R6", 20'h00107, 12'hFFF, 4'h1, 0, 0, 20'h00207);
    endtask

    task automatic t_context();
        lookup(20'h00100, 12'h0, 4'h2, 0, 0);
        chk("R3", "foreign context misses", s_miss, 1);
        respond("R3", 20'h00100, 4'h2, 0, '0, '0);
        chk("R7", "page_fault", s_pgf, 1);
        expect_absent("R7", 20'h00100, 4'h2);
        expect_hit("R3", 20'h00100, 12'h004, 4'h1, 0, 0, 20'h00200);
    endtask

    task automatic t_perm();
        lookup(20'h00100, 12'h0, 4'h1, 1, 0);
        chk("R4", "write to read-only faults", s_pf, 1);
        chk("R4", "no hit", s_hit, 0);
        chk("R4", "no miss", s_miss, 0);
        chk("R4", "no refill", rf_req, 0);
        lookup(20'h00101, 12'h0, 4'h1, 0, 1);
        chk("R4", "user on supervisor page faults", s_pf, 1);
        chk("R4", "no refill", rf_req, 0);
        lookup(20'h00102, 12'h0, 4'h1, 1, 1);
        chk("R4", "user write to user read-only faults", s_pf, 1);
        expect_hit("R4", 20'h00103, 12'h123, 4'h1, 1, 1, 20'h00203);
        expect_hit("R10", 20'h00101, 12'h010, 4'h1, 1, 0, 20'h00201);
    endtask

    task automatic t_evict();
        install("R9", 20'h00180, 4'h1, 20'h00300, 2'b11, 1, 20'h00100, 4'h1, 0);
        install("R9", 20'h00181, 4'h1, 20'h00301, 2'b11, 1, 20'h00101, 4'h1, 1);
        expect_hit("R9", 20'h00180, 12'h008, 4'h1, 0, 0, 20'h00300);
    endtask

    task automatic t_invalidate();
        @(negedge clk);
        inv_valid = 1; inv_vpn = 20'h00102;
        @(posedge clk); #1;
        inv_valid = 0;
        expect_absent("R12", 20'h00102, 4'h1);
        expect_hit("R12", 20'h00105, 12'h055, 4'h1, 0, 0, 20'h00205);
        install("R13", 20'h00190, 4'h1, 20'h00400, 2'b01, 0, '0, '0, 0);
        install("R13", 20'h00191, 4'h1, 20'h00401, 2'b01, 1, 20'h00190, 4'h1, 0);
        install("R9", 20'h001A0, 4'h3, 20'h00500, 2'b11, 1, 20'h00103, 4'h1, 1);
        install("R9", 20'h001A0, 4'h5, 20'h00501, 2'b11, 1, 20'h00104, 4'h1, 0);
        expect_hit("R3", 20'h001A0, 12'h001, 4'h5, 0, 0, 20'h00501);
        @(negedge clk);
        inv_valid = 1; inv_vpn = 20'h001A0;
        @(posedge clk); #1;
        inv_valid = 0;
        expect_absent("R12", 20'h001A0, 4'h3);
        expect_absent("R12", 20'h001A0, 4'h5);
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush_all = 1;
        @(posedge clk); #1;
        flush_all = 0;
        expect_absent("R11", 20'h00105, 4'h1);
        expect_absent("R11", 20'h00180, 4'h1);
    endtask

    task automatic t_pending();
        lookup(20'h00300, 12'h0, 4'h6, 0, 0);
        chk("R5", "miss A", s_miss, 1);
        lookup(20'h00301, 12'h0, 4'h7, 0, 0);
        chk("R5", "miss B", s_miss, 1);
        respond("R5", 20'h00300, 4'h6, 1, 20'h00007, 2'b11);
        chk("R8", "no wb into empty cache", s_wb, 0);
        expect_hit("R6", 20'h00300, 12'hABC, 4'h6, 1, 1, 20'h00007);
        expect_absent("R5", 20'h00301, 4'h7);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_fill();
        t_context();
        t_perm();
        t_evict();
        t_invalidate();
        t_flush();
        t_pending();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule